// File: doc/BRIEF.md
# Multichannel Interrupt Fan-out Multiplexer

This block gathers a vector of level-sensitive, active-high interrupt sources and offers every one of them to a set of independent output channels. Each channel keeps its own enable mask. A channel raises its single interrupt line to the processor's interrupt controller while any source that it has enabled is high. A source can be enabled on several channels at the same time. Software sets and clears enable bits one at a time through read-modify-write. It then reads a per-channel pending word to find which enabled sources are active.

The sources are first brought into the clock domain through a synchronizer. Each channel's pending word is the synchronized source vector ANDed with that channel's mask. The interrupt line is a registered OR of the pending word. Pending bits are pure levels and need no clear. Software reaches the channels through a single-cycle register bus with combinational read data. Each channel occupies a 0x40-byte window: its enable word sits at window offset 0x10 and its pending word at offset 0x20.

Top module: `irq_fanout_mux`

## Requirements
- R1: While reset is held, and directly after it, every enable register reads zero and every channel output is low.
- R2: A write to byte address 0x10 + 0x40*n, for n below the channel count, loads channel n's enable register. A read of that address returns exactly the last value written. Bit i of this register enables source i.
- R3: A read of byte address 0x20 + 0x40*n returns the synchronized source vector ANDed with channel n's enable register. A source change shows up there after the second rising edge.
- R4: Channel n's output is the OR of its pending bits, registered once. A source change reaches the output at the third rising edge after the change.
- R5: One source enabled on several channels asserts all of those channels together. Writing one channel's enable register leaves the enable registers of the other channels unchanged.
- R6: A new enable value reaches the channel output one clock edge after the edge that captures the write. At the capturing edge the output still reflects the old mask.
- R7: A pending bit and its channel output stay set for as long as the source stays high and enabled, with no write needed. They clear when the source falls or when the enable bit is cleared.
- R8: Writes to pending addresses, to other offsets inside a window, and to windows at or beyond the channel count change no enable register and no output.
- R9: Reads of any address other than a mapped enable or pending word return zero. This includes the enable offset of the first window past the last channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface and logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | NUM_SRC | Level-sensitive active-high interrupt sources |
| regAddr | input | ADDR_W | Register bus byte address |
| regWrEn | input | 1 | Register bus write strobe, one cycle per write |
| regWrData | input | DATA_W | Register bus write data |
| regRdData | output | DATA_W | Register bus read data, combinational from address |
| chanIrq | output | NUM_CHAN | One interrupt line per channel |

## Verification
The bench builds the block with its default parameters: eight channels, 32 sources, a 12-bit address and a two-stage synchronizer. With these values the highest channel window (0x1C0), the most significant source bit and the first unmapped window (0x200) can all be addressed directly. The bench counts edges after a source change and after an enable write, so that the two-edge pending latency and the three-edge output latency are pinned to exact cycles. The vector table mixes sparse, dense, disjoint and single-bit masks across the channels.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

  // Width of the channel index carried in the strobe bundle
  localparam int CHAN_IDX_W = 6;

  // Window layout: 0x40 bytes per channel
  localparam int WIN_SHIFT = 6;
  localparam logic [WIN_SHIFT-1:0] ENABLE_OFS  = 6'h10;
  localparam logic [WIN_SHIFT-1:0] PENDING_OFS = 6'h20;

  typedef struct packed {
    logic                  enWr;    // load the selected enable register
    logic                  enRd;    // return the selected enable register
    logic                  pendRd;  // return the selected pending word
    logic [CHAN_IDX_W-1:0] chan;    // selected channel
  } regStrobe_t;

endpackage

// File: rtl/irqmux_sync.sv
module irqmux_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/irqmux_ctrl.sv
module irqmux_ctrl
  import irqmux_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 12
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam int FIELD_W = ADDR_W - WIN_SHIFT;

  logic [FIELD_W-1:0]   chanField;
  logic [WIN_SHIFT-1:0] winOfs;
  logic                 chanValid;
  logic                 hitEnable;
  logic                 hitPending;

  assign chanField  = regAddr[ADDR_W-1:WIN_SHIFT];
  assign winOfs     = regAddr[WIN_SHIFT-1:0];
  assign chanValid  = int'(chanField) < NUM_CHAN;
  assign hitEnable  = chanValid && (winOfs == ENABLE_OFS);
  assign hitPending = chanValid && (winOfs == PENDING_OFS);

  always_comb begin
    strobe        = '0;
    strobe.enWr   = regWrEn && hitEnable;
    strobe.enRd   = hitEnable;
    strobe.pendRd = hitPending;
    strobe.chan   = CHAN_IDX_W'(chanField);
  end

endmodule

// File: rtl/irqmux_datapath.sv
module irqmux_datapath
  import irqmux_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int NUM_SRC  = 32,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strobe,
  input  logic [DATA_W-1:0]            regWrData,
  input  logic [NUM_SRC-1:0]           srcSync,
  output logic [DATA_W-1:0]            regRdData,
  output logic [NUM_CHAN-1:0]          chanIrq,
  output logic [NUM_CHAN*NUM_SRC-1:0]  enFlat
);

  logic [NUM_SRC-1:0] enReg   [NUM_CHAN];
  logic [NUM_SRC-1:0] pendVec [NUM_CHAN];
  logic [NUM_CHAN-1:0] irqQ;

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
      logic selMe;
      assign selMe = (strobe.chan == CHAN_IDX_W'(c));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    enReg[c] <= '0;
        else if (strobe.enWr && selMe) enReg[c] <= regWrData[NUM_SRC-1:0];
      end

      assign pendVec[c] = srcSync & enReg[c];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqQ[c] <= 1'b0;
        else       irqQ[c] <= |pendVec[c];
      end

      assign enFlat[c*NUM_SRC +: NUM_SRC] = enReg[c];
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (strobe.chan == CHAN_IDX_W'(c)) begin
        if (strobe.enRd)   regRdData = DATA_W'(enReg[c]);
        if (strobe.pendRd) regRdData = DATA_W'(pendVec[c]);
      end
    end
  end

  assign chanIrq = irqQ;

endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIrq,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_CHAN-1:0] chanIrq
);

  regStrobe_t                  strobe;
  logic [NUM_SRC-1:0]          srcSync;
  logic [NUM_CHAN*NUM_SRC-1:0] enFlat;

  irqmux_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (srcIrq),
    .syncOut (srcSync)
  );

  irqmux_ctrl #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irqmux_datapath #(.NUM_CHAN(NUM_CHAN), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .srcSync   (srcSync),
    .regRdData (regRdData),
    .chanIrq   (chanIrq),
    .enFlat    (enFlat)
  );

endmodule

// File: rtl/irqmux_checker.sv
module irqmux_checker #(
  parameter int NUM_CHAN = 8,
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [ADDR_W-1:0]           regAddr,
  input logic                        regWrEn,
  input logic [DATA_W-1:0]           regWrData,
  input logic [DATA_W-1:0]           regRdData,
  input logic [NUM_CHAN-1:0]         chanIrq,
  input logic [NUM_SRC-1:0]          srcSync,
  input logic [NUM_CHAN*NUM_SRC-1:0] enFlat
);

  logic inWin;
  logic isEnAddr;
  logic isPendAddr;

  assign inWin      = int'(regAddr[ADDR_W-1:6]) < NUM_CHAN;
  assign isEnAddr   = inWin && (regAddr[5:0] == 6'h10);
  assign isPendAddr = inWin && (regAddr[5:0] == 6'h20);

  // R1: outputs and masks are quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (chanIrq == '0 && enFlat == '0);
    end
  end

  // R8: writes outside the enable words leave every mask alone
  a_r8_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !isEnAddr) |=> $stable(enFlat));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!isEnAddr && !isPendAddr) |-> (regRdData == '0));

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : gChk
      // R2: enable write lands in the addressed register
      a_r2_enable_load: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regAddr == ADDR_W'(16 + 64 * c)) |=>
          (enFlat[c*NUM_SRC +: NUM_SRC] == $past(regWrData[NUM_SRC-1:0])));

      // R3: pending read is synchronized sources masked by enable
      a_r3_pending_read: assert property (@(posedge clk) disable iff (!rstN)
        (regAddr == ADDR_W'(32 + 64 * c)) |->
          (regRdData == DATA_W'(srcSync & enFlat[c*NUM_SRC +: NUM_SRC])));

      // R4: output is the registered OR of the pending bits
      a_r4_output_or: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (chanIrq[c] == $past(|(srcSync & enFlat[c*NUM_SRC +: NUM_SRC]))));
    end
  endgenerate

endmodule

bind irq_fanout_mux irqmux_checker #(
  .NUM_CHAN (NUM_CHAN),
  .NUM_SRC  (NUM_SRC),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .chanIrq   (chanIrq),
  .srcSync   (srcSync),
  .enFlat    (enFlat)
);

// File: tb/irq_fanout_mux_test.sv
module irq_fanout_mux_test;

  localparam int NUM_CHAN = 8;
  localparam int NUM_SRC  = 32;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;

  logic                clk = 1'b0;
  logic                rstN;
  logic [NUM_SRC-1:0]  srcIrq;
  logic [ADDR_W-1:0]   regAddr;
  logic                regWrEn;
  logic [DATA_W-1:0]   regWrData;
  logic [DATA_W-1:0]   regRdData;
  logic [NUM_CHAN-1:0] chanIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_fanout_mux uut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .chanIrq(chanIrq)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] en;
    logic [31:0] src;
    logic [31:0] expPend;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
    '{3'd3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000},
    '{3'd7, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},
    '{3'd5, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678},
    '{3'd2, 32'h0000_FFFF, 32'hA5A5_0000, 32'h0000_0000},
    '{3'd1, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'hAAAA_0000}
  };

  function automatic logic [ADDR_W-1:0] enAddr(int ch);
    return ADDR_W'(32'h10 + 32'h40 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] pendAddr(int ch);
    return ADDR_W'(32'h20 + 32'h40 * ch);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    tick();
    regWrEn   = 1'b0;
  endtask

  task automatic regRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; srcIrq = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) tick();

    // R1: reset state
    check("R1 irq in reset", 32'(chanIrq), 32'h0);
    regRead(enAddr(0), rd); check("R1 enable ch0 in reset", rd, 32'h0);
    rstN = 1'b1;
    tick();
    regRead(enAddr(7), rd); check("R1 enable ch7 after reset", rd, 32'h0);
    check("R1 irq after reset", 32'(chanIrq), 32'h0);

    // Table walk: R2 readback, R3 pending, R4 output
    for (int i = 0; i < NVEC; i++) begin
      regWrite(enAddr(int'(VECS[i].ch)), VECS[i].en);
      srcIrq = VECS[i].src;
      repeat (3) tick();
      regRead(pendAddr(int'(VECS[i].ch)), rd);
      check("R3 pending table", rd, VECS[i].expPend);
      check("R4 output table", 32'(chanIrq[VECS[i].ch]), 32'(|VECS[i].expPend));
      regRead(enAddr(int'(VECS[i].ch)), rd);
      check("R2 readback table", rd, VECS[i].en);
      regWrite(enAddr(int'(VECS[i].ch)), 32'h0);
      srcIrq = '0;
      repeat (3) tick();
      check("R4 output idle", 32'(chanIrq), 32'h0);
    end

    // R4 and R3 latency: source rises, count edges
    regWrite(enAddr(4), 32'h0000_0100);
    srcIrq = 32'h0000_0100;
    tick();
    regRead(pendAddr(4), rd); check("R3 pending after edge 1", rd, 32'h0);
    tick();
    regRead(pendAddr(4), rd); check("R3 pending after edge 2", rd, 32'h0000_0100);
    check("R4 output after edge 2", 32'(chanIrq[4]), 32'h0);
    tick();
    check("R4 output after edge 3", 32'(chanIrq[4]), 32'h1);

    // R7: level hold without writes, then source drop
    repeat (10) tick();
    check("R7 output held", 32'(chanIrq[4]), 32'h1);
    regRead(pendAddr(4), rd); check("R7 pending held", rd, 32'h0000_0100);
    srcIrq = '0;
    repeat (2) tick();
    check("R7 output before drop lands", 32'(chanIrq[4]), 32'h1);
    tick();
    check("R7 output after source falls", 32'(chanIrq[4]), 32'h0);

    // R6: enable write latency with source already synchronized
    regWrite(enAddr(4), 32'h0);
    srcIrq = 32'h0000_0040;
    repeat (3) tick();
    check("R6 output still masked", 32'(chanIrq[4]), 32'h0);
    regWrite(enAddr(4), 32'h0000_0040);
    check("R6 output at capturing edge", 32'(chanIrq[4]), 32'h0);
    tick();
    check("R6 output one edge later", 32'(chanIrq[4]), 32'h1);
    // R7: clearing the enable drops it
    regWrite(enAddr(4), 32'h0);
    tick();
    check("R7 output after enable cleared", 32'(chanIrq[4]), 32'h0);

    // R5: fan-out of source 5 to channels 1, 4, 6
    srcIrq = 32'h0000_0020;
    regWrite(enAddr(1), 32'h0000_0020);
    regWrite(enAddr(4), 32'h0000_0020);
    regWrite(enAddr(6), 32'h0000_0020);
    repeat (3) tick();
    check("R5 fan-out outputs", 32'(chanIrq), 32'h0000_0052);
    regRead(enAddr(1), rd); check("R5 ch1 untouched by later writes", rd, 32'h0000_0020);
    regRead(enAddr(0), rd); check("R5 ch0 untouched", rd, 32'h0);
    regWrite(enAddr(1), 32'h0);
    regWrite(enAddr(4), 32'h0);
    regWrite(enAddr(6), 32'h0);
    tick();

    // R8: stray writes with all sources high
    srcIrq = '1;
    repeat (3) tick();
    regWrite(pendAddr(0), 32'hFFFF_FFFF);
    regWrite(12'h014, 32'hFFFF_FFFF);
    regWrite(12'h030, 32'hFFFF_FFFF);
    regWrite(12'h210, 32'hFFFF_FFFF);
    regWrite(12'h000, 32'hFFFF_FFFF);
    tick();
    check("R8 outputs after stray writes", 32'(chanIrq), 32'h0);
    regRead(enAddr(0), rd); check("R8 ch0 enable after stray writes", rd, 32'h0);
    regRead(pendAddr(0), rd); check("R8 ch0 pending after stray writes", rd, 32'h0);

    // R9: unmapped reads with a live channel
    regWrite(enAddr(0), 32'hFFFF_FFFF);
    regRead(12'h014, rd); check("R9 read 0x014", rd, 32'h0);
    regRead(12'h000, rd); check("R9 read 0x000", rd, 32'h0);
    regRead(12'h210, rd); check("R9 read 0x210", rd, 32'h0);
    regRead(12'h220, rd); check("R9 read 0x220", rd, 32'h0);
    regRead(pendAddr(0), rd); check("R3 pending all high", rd, 32'hFFFF_FFFF);

    done = 1;
    summary();
    $finish;
  end

endmodule